// File: doc/BRIEF.md
# Multi-Mode PWM Timer/Counter

This block is an 8-bit timer/counter with a waveform generator that drives two compare channels, A and B. A 3-bit mode field picks the counting sequence: a plain wrap-around count, a count that restarts on the channel A compare value, single-slope PWM, or dual-slope (up/down) PWM. The mode also sets where TOP comes from, when newly written compare values take effect, and at which point of the count the overflow flag is raised. The counter only moves on cycles where the externally prescaled `cnt_en` strobe is high.

Compare values are written through a small register port into per-channel buffers. Depending on the mode, a buffer is used directly or is copied into the active compare value at TOP or at BOTTOM. Each channel has a 2-bit output-mode field that selects whether its output is driven and how compare matches and period boundaries shape it. All outputs are registered, and the flags are single-cycle pulses.

Top module: `wavetimer8`

## Requirements
- R1: While `rst` is high and in the first cycle after it: `count` is 0, `wave_a`, `wave_b`, `oe_a`, `oe_b`, `ovf_flag`, `match_a` and `match_b` are 0, and both compare values are 0.
- R2: `count` changes only on clock edges where `cnt_en` is high. In modes 0, 2, 3, 4, 6 and 7 each step adds one, and a step taken at or above TOP goes to 0. TOP is 255 in modes 0, 1, 3, 4 and 6, and the channel A compare value in modes 2, 5 and 7.
- R3: In modes 1 and 5 (dual slope), `count` rises to TOP and falls to 0. The step taken at TOP is the first step down, the step taken at 0 is the first step up, and consecutive values differ by exactly one.
- R4: `ovf_flag` is high for one cycle after a step taken at count 255 in modes 0, 2, 3, 4 and 6, at count 0 in modes 1 and 5, and at TOP in mode 7.
- R5: `match_a`/`match_b` is high for one cycle after a step taken while `count` equals that channel's compare value in effect.
- R6: A write with `wr_en` high stores `wr_data` into the buffer of channel A (`wr_sel`=0) or B (`wr_sel`=1). The buffer is in effect at once in modes 0, 2, 4 and 6. In modes 1, 3 and 5 it takes effect from the step taken at TOP, and in mode 7 from the step taken at 0.
- R7: In modes 0, 2, 4 and 6, a compare match toggles the output for output-mode 01, clears it for 10 and sets it for 11.
- R8: In modes 3 and 7, output-mode 10 sets the output on the step at TOP and clears it on a match, so for compare value c the output is high for c+1 of every TOP+1 steps. Output-mode 11 gives the complement.
- R9: In modes 1 and 5, output-mode 10 clears the output on a match during an up step and sets it on a match during a down step, which gives 2c high steps in every 2·TOP. Output-mode 11 gives the complement.
- R10: In modes 1 and 5, when the compare value equals TOP and output-mode is 1x, the match is ignored and the output is set (10) or cleared (11) at the TOP step, so it stays constantly high (10) or constantly low (11).
- R11: One cycle after the output-mode changes, `oe_x` is 0 for output-mode 00, 0 for output-mode 01 in modes 1, 3, 5 and 7, and 1 otherwise.
- R12: Reserved modes 4 and 6 behave exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Prescaled count-enable strobe |
| wr_en | input | 1 | Compare buffer write strobe |
| wr_sel | input | 1 | Channel select for the write: 0 = A, 1 = B |
| wr_data | input | 8 | Compare value to write |
| mode | input | 3 | Counting/waveform mode, 0 to 7 |
| cmode_a | input | 2 | Channel A output-mode field |
| cmode_b | input | 2 | Channel B output-mode field |
| count | output | 8 | Current counter value |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| oe_a | output | 1 | Channel A output enable |
| oe_b | output | 1 | Channel B output enable |
| ovf_flag | output | 1 | Overflow pulse |
| match_a | output | 1 | Channel A compare-match pulse |
| match_b | output | 1 | Channel B compare-match pulse |

## Verification
The PWM duty is swept over compare values at both ends of the range and in the middle, in both polarities, for the single- and dual-slope modes. The count of high steps per period then separates the set-at-TOP rule, the direction-dependent rule and the equal-to-TOP special case. For the update point, a compare value is rewritten part way through a period, and the count at which the next match occurs shows whether the value took effect at once, at TOP or at BOTTOM. The restart-on-compare and reserved modes are run to their wrap points, which shows the effective TOP, where the overflow flag lands, and toggle behaviour.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef struct packed {
    logic top_a;    // TOP taken from channel A compare value
    logic phase;    // dual-slope counting
    logic fast;     // single-slope PWM
    logic upd_top;  // buffered compare loads on TOP step
    logic upd_bot;  // buffered compare loads on BOTTOM step
    logic ovf_bot;  // overflow on BOTTOM step
    logic ovf_top;  // overflow on TOP step
  } wt_cfg_t;

  function automatic wt_cfg_t wt_decode(input logic [2:0] m);
    wt_cfg_t c;
    c = '0;
    case (m)
      3'd1: begin c.phase = 1'b1; c.upd_top = 1'b1; c.ovf_bot = 1'b1; end
      3'd2: begin c.top_a = 1'b1; end
      3'd3: begin c.fast = 1'b1; c.upd_top = 1'b1; end
      3'd5: begin c.top_a = 1'b1; c.phase = 1'b1; c.upd_top = 1'b1; c.ovf_bot = 1'b1; end
      3'd7: begin c.top_a = 1'b1; c.fast = 1'b1; c.upd_bot = 1'b1; c.ovf_top = 1'b1; end
      default: ; // 0, 4, 6: plain wrap-around count
    endcase
    return c;
  endfunction

endpackage

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         phase_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         at_top_o,
  output logic         at_bot_o,
  output logic         up_step_o
);

  logic [W-1:0] cnt_q;
  logic         dn_q;

  assign cnt_o    = cnt_q;
  assign at_top_o = (cnt_q >= top_i);
  assign at_bot_o = (cnt_q == '0);
  // direction of the step that the next enable would take
  assign up_step_o = !phase_i || (dn_q ? at_bot_o : !at_top_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (en_i) begin
      if (!phase_i) begin
        dn_q  <= 1'b0;
        cnt_q <= at_top_o ? '0 : cnt_q + 1'b1;
      end else if (!dn_q) begin
        if (at_top_o) begin
          dn_q  <= 1'b1;
          cnt_q <= at_bot_o ? '0 : cnt_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        if (at_bot_o) begin
          dn_q  <= 1'b0;
          cnt_q <= at_top_o ? '0 : cnt_q + 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wt_cmp_bank.sv
module wt_cmp_bank #(
  parameter int W  = 8,
  parameter int CH = 2,
  localparam int SEL_W = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en_i,
  input  logic [SEL_W-1:0]      wr_sel_i,
  input  logic [W-1:0]          wr_data_i,
  input  logic                  imm_i,
  input  logic                  load_i,
  output logic [CH-1:0][W-1:0]  eff_o
);

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [W-1:0] buf_q;
    logic [W-1:0] act_q;
    logic         hit;

    assign hit = wr_en_i && (wr_sel_i == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        buf_q <= '0;
        act_q <= '0;
      end else begin
        if (hit) buf_q <= wr_data_i;
        if (imm_i || load_i) act_q <= buf_q;
      end
    end

    assign eff_o[g] = imm_i ? buf_q : act_q;
  end

endmodule

// File: rtl/wt_wavegen.sv
module wt_wavegen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         phase_i,
  input  logic         fast_i,
  input  logic [1:0]   cmode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] top_i,
  input  logic         at_top_i,
  input  logic         up_step_i,
  output logic         wave_o,
  output logic         oe_o
);

  logic wave_q;
  logic oe_q;
  logic wave_d;
  logic hit;
  logic pwm;

  assign hit = (cnt_i == cmp_i);
  assign pwm = phase_i || fast_i;

  always_comb begin
    wave_d = wave_q;
    if (phase_i) begin
      if (cmode_i[1]) begin
        if (cmp_i == top_i) begin
          if (at_top_i) wave_d = ~cmode_i[0];
        end else if (hit) begin
          wave_d = up_step_i ? cmode_i[0] : ~cmode_i[0];
        end
      end
    end else if (fast_i) begin
      if (cmode_i[1]) begin
        if (at_top_i)  wave_d = ~cmode_i[0];
        else if (hit)  wave_d = cmode_i[0];
      end
    end else if (hit) begin
      case (cmode_i)
        2'b01:   wave_d = ~wave_q;
        2'b10:   wave_d = 1'b0;
        2'b11:   wave_d = 1'b1;
        default: wave_d = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= (cmode_i != 2'b00) && !(pwm && cmode_i == 2'b01);
      if (en_i) wave_q <= wave_d;
    end
  end

  assign wave_o = wave_q;
  assign oe_o   = oe_q;

endmodule

// File: rtl/wavetimer8.sv
module wavetimer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   mode,
  input  logic [1:0]   cmode_a,
  input  logic [1:0]   cmode_b,
  output logic [W-1:0] count,
  output logic         wave_a,
  output logic         wave_b,
  output logic         oe_a,
  output logic         oe_b,
  output logic         ovf_flag,
  output logic         match_a,
  output logic         match_b
);
  import wt_pkg::*;

  localparam int          CH   = 2;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  wt_cfg_t              cfg;
  logic [CH-1:0][W-1:0] eff;
  logic [W-1:0]         top;
  logic [W-1:0]         cnt;
  logic                 at_top, at_bot, up_step;
  logic                 imm, load;
  logic [CH-1:0][1:0]   cm;
  logic [CH-1:0]        wave_v, oe_v;
  logic [CH-1:0]        match_q;
  logic                 ovf_q;

  assign cfg  = wt_decode(mode);
  assign imm  = !(cfg.upd_top || cfg.upd_bot);
  assign top  = cfg.top_a ? eff[0] : MAXV;
  assign load = cnt_en && ((cfg.upd_top && at_top) || (cfg.upd_bot && at_bot));
  assign cm   = {cmode_b, cmode_a};

  wt_cmp_bank #(.W(W), .CH(CH)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .imm_i     (imm),
    .load_i    (load),
    .eff_o     (eff)
  );

  wt_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .en_i      (cnt_en),
    .phase_i   (cfg.phase),
    .top_i     (top),
    .cnt_o     (cnt),
    .at_top_o  (at_top),
    .at_bot_o  (at_bot),
    .up_step_o (up_step)
  );

  for (genvar g = 0; g < CH; g++) begin : g_wave
    wt_wavegen #(.W(W)) u_wg (
      .clk       (clk),
      .rst       (rst),
      .en_i      (cnt_en),
      .phase_i   (cfg.phase),
      .fast_i    (cfg.fast),
      .cmode_i   (cm[g]),
      .cnt_i     (cnt),
      .cmp_i     (eff[g]),
      .top_i     (top),
      .at_top_i  (at_top),
      .up_step_i (up_step),
      .wave_o    (wave_v[g]),
      .oe_o      (oe_v[g])
    );

    always_ff @(posedge clk) begin
      if (rst) match_q[g] <= 1'b0;
      else     match_q[g] <= cnt_en && (cnt == eff[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= cnt_en && (cfg.ovf_bot ? at_bot :
                          cfg.ovf_top ? at_top : (cnt == MAXV));
    end
  end

  assign count    = cnt;
  assign wave_a   = wave_v[0];
  assign wave_b   = wave_v[1];
  assign oe_a     = oe_v[0];
  assign oe_b     = oe_v[1];
  assign match_a  = match_q[0];
  assign match_b  = match_q[1];
  assign ovf_flag = ovf_q;

endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic [2:0]   mode,
  input logic [1:0]   cmode_a,
  input logic [W-1:0] count,
  input logic         oe_a,
  input logic         ovf_flag,
  input logic         match_a,
  input logic         match_b
);

  logic ph_now;
  assign ph_now = (mode == 3'd1) || (mode == 3'd5);

  a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count));

  a_r2_linear_step: assert property (@(posedge clk) disable iff (rst)
    cnt_en && !ph_now |=> (count == W'($past(count) + 1'b1)) || (count == '0));

  a_r3_dual_slope_step: assert property (@(posedge clk) disable iff (rst)
    cnt_en && ph_now |=> (count == W'($past(count) + 1'b1)) ||
                         (count == W'($past(count) - 1'b1)) ||
                         (count == '0 && $past(count) == '0));

  a_r4_ovf_lands_on_zero: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !$past(ph_now) |-> count == '0);

  a_r4_ovf_needs_step: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> $past(cnt_en));

  a_r5_match_needs_step: assert property (@(posedge clk) disable iff (rst)
    (match_a || match_b) |-> $past(cnt_en));

  a_r11_oe_off_when_disconnected: assert property (@(posedge clk) disable iff (rst)
    $past(cmode_a) == 2'b00 |-> !oe_a);

endmodule

bind wavetimer8 wt_checker #(.W(W)) u_wt_checker (
  .clk      (clk),
  .rst      (rst),
  .cnt_en   (cnt_en),
  .mode     (mode),
  .cmode_a  (cmode_a),
  .count    (count),
  .oe_a     (oe_a),
  .ovf_flag (ovf_flag),
  .match_a  (match_a),
  .match_b  (match_b)
);

// File: tb/test_wavetimer8.sv
`timescale 1ns/1ps
module test_wavetimer8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] mode = '0;
  logic [1:0] cmode_a = '0;
  logic [1:0] cmode_b = '0;
  logic [7:0] count;
  logic       wave_a, wave_b, oe_a, oe_b, ovf_flag, match_a, match_b;

  int n_tests = 0;
  int n_fail  = 0;

  int w_hi_a, w_hi_b, w_ovf, w_ovf_at, w_ma, w_mb, w_first_mb;
  int w_max, w_min, w_tog_a, w_bad_step;

  always #2.5 clk = ~clk;

  wavetimer8 #(.W(8)) i_wavetimer8 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mode(mode), .cmode_a(cmode_a), .cmode_b(cmode_b),
    .count(count), .wave_a(wave_a), .wave_b(wave_b), .oe_a(oe_a), .oe_b(oe_b),
    .ovf_flag(ovf_flag), .match_a(match_a), .match_b(match_b)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cnt_en = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk) cnt_en = 1'b1;
    @(negedge clk) cnt_en = 1'b0;
  endtask

  task automatic wr(input logic sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    w_hi_a = 0; w_hi_b = 0; w_ovf = 0; w_ovf_at = -1; w_ma = 0; w_mb = 0;
    w_first_mb = -1; w_max = 0; w_min = 255; w_tog_a = 0; w_bad_step = 0;
    for (int i = 0; i < n; i++) begin
      int   pc;
      int   d;
      logic pw;
      pc = int'(count);
      pw = wave_a;
      tick();
      d = int'(count) - pc;
      if (d != 1 && d != -1 && !(count == 8'd0 && pc == 0)) w_bad_step++;
      if (wave_a) w_hi_a++;
      if (wave_b) w_hi_b++;
      if (wave_a != pw) w_tog_a++;
      if (ovf_flag) begin w_ovf++; w_ovf_at = int'(count); end
      if (match_a) w_ma++;
      if (match_b) begin
        if (w_mb == 0) w_first_mb = int'(count);
        w_mb++;
      end
      if (int'(count) > w_max) w_max = int'(count);
      if (int'(count) < w_min) w_min = int'(count);
    end
  endtask

  initial begin
    int fast_c[5] = '{0, 37, 128, 254, 255};
    int dual_c[3] = '{0, 60, 200};

    // R1: reset state
    do_reset();
    chk("R1 count", int'(count), 0);
    chk("R1 waves", int'({wave_a, wave_b}), 0);
    chk("R1 enables", int'({oe_a, oe_b}), 0);
    chk("R1 flags", int'({ovf_flag, match_a, match_b}), 0);

    // R2/R4: mode 0 stepping, hold, wrap at MAX
    mode = 3'd0;
    run(5);
    chk("R2 five steps", int'(count), 5);
    repeat (20) @(negedge clk);
    chk("R2 hold without enable", int'(count), 5);
    run(250);
    chk("R2 reach 255", int'(count), 255);
    chk("R4 no early overflow", w_ovf, 0);
    run(1);
    chk("R2 wrap to 0", int'(count), 0);
    chk("R4 overflow at MAX", w_ovf, 1);

    // R5/R7/R11: non-PWM output modes
    do_reset();
    mode = 3'd0; cmode_b = 2'b11;
    wr(1'b1, 100);
    run(256);
    chk("R5 one match", w_mb, 1);
    chk("R5 match after count 100", w_first_mb, 101);
    chk("R7 set on match", int'(wave_b), 1);
    chk("R11 oe for 11", int'(oe_b), 1);
    chk("R1 compare A zero after reset", w_ma, 1);
    cmode_b = 2'b10; run(256);
    chk("R7 clear on match", int'(wave_b), 0);
    cmode_b = 2'b01; run(256);
    chk("R7 toggle first", int'(wave_b), 1);
    run(256);
    chk("R7 toggle second", int'(wave_b), 0);

    // R6: immediate update in mode 0
    do_reset();
    mode = 3'd0;
    wr(1'b1, 200);
    run(10);
    wr(1'b1, 50);
    run(100);
    chk("R6 immediate update", w_first_mb, 51);

    // R6: update at TOP in mode 3
    do_reset();
    mode = 3'd3;
    wr(1'b1, 200);
    run(256);
    run(10);
    wr(1'b1, 50);
    run(245);
    chk("R6 mode3 old value kept", w_first_mb, 201);
    chk("R6 mode3 single match", w_mb, 1);
    run(256);
    chk("R6 mode3 new value after TOP", w_first_mb, 51);

    // R8/R4: fast PWM duty, TOP 255
    do_reset();
    mode = 3'd3; cmode_a = 2'b10;
    for (int k = 0; k < 5; k++) begin
      wr(1'b0, fast_c[k]);
      run(512);
      run(256);
      chk("R8 fast duty non-inverting", w_hi_a, fast_c[k] + 1);
      chk("R4 mode3 one overflow", w_ovf, 1);
      chk("R4 mode3 overflow at wrap", w_ovf_at, 0);
    end
    cmode_a = 2'b11;
    wr(1'b0, 37);
    run(512);
    run(256);
    chk("R8 fast duty inverting", w_hi_a, 256 - 38);
    cmode_a = 2'b01;
    repeat (2) @(negedge clk);
    chk("R11 oe off for 01 in PWM", int'(oe_a), 0);
    cmode_a = 2'b00;
    repeat (2) @(negedge clk);
    chk("R11 oe off for 00", int'(oe_a), 0);

    // R2/R4/R8: fast PWM with TOP from channel A, update at BOTTOM
    do_reset();
    mode = 3'd7; cmode_b = 2'b10;
    wr(1'b0, 99);
    wr(1'b1, 30);
    run(200);
    run(100);
    chk("R8 mode7 duty", w_hi_b, 31);
    chk("R4 mode7 one overflow", w_ovf, 1);
    chk("R4 mode7 overflow at TOP", w_ovf_at, 0);
    chk("R2 mode7 TOP from A", w_max, 99);
    chk("R5 mode7 one match", w_mb, 1);

    // R2/R7: restart on compare A
    do_reset();
    mode = 3'd2; cmode_a = 2'b01;
    wr(1'b0, 49);
    run(50);
    run(500);
    chk("R7 toggles per period", w_tog_a, 10);
    chk("R5 matches per period", w_ma, 10);
    chk("R4 mode2 no overflow below MAX", w_ovf, 0);
    chk("R2 mode2 TOP from A", w_max, 49);

    // R3/R9/R4: dual slope, TOP 255
    do_reset();
    mode = 3'd1; cmode_a = 2'b10;
    for (int k = 0; k < 3; k++) begin
      wr(1'b0, dual_c[k]);
      run(1020);
      run(510);
      chk("R9 dual duty non-inverting", w_hi_a, 2 * dual_c[k]);
      chk("R3 unit steps", w_bad_step, 0);
      chk("R3 peak", w_max, 255);
      chk("R3 floor", w_min, 0);
      chk("R4 mode1 one overflow", w_ovf, 1);
      chk("R4 mode1 overflow at BOTTOM", w_ovf_at, 1);
    end
    cmode_a = 2'b11;
    wr(1'b0, 60);
    run(1020);
    run(510);
    chk("R9 dual duty inverting", w_hi_a, 510 - 120);
    cmode_a = 2'b10;
    wr(1'b0, 255);
    run(1020);
    run(510);
    chk("R10 equal TOP non-inverting high", w_hi_a, 510);
    cmode_a = 2'b11;
    run(1020);
    run(510);
    chk("R10 equal TOP inverting low", w_hi_a, 0);

    // R3/R9: dual slope with TOP from channel A
    do_reset();
    mode = 3'd5; cmode_b = 2'b10;
    wr(1'b0, 80);
    wr(1'b1, 30);
    run(400);
    run(160);
    chk("R9 mode5 duty", w_hi_b, 60);
    chk("R3 mode5 peak", w_max, 80);
    chk("R3 mode5 unit steps", w_bad_step, 0);
    chk("R4 mode5 one overflow", w_ovf, 1);

    // R6: update at TOP in dual slope
    do_reset();
    mode = 3'd1; cmode_b = 2'b10;
    wr(1'b1, 100);
    run(256);
    chk("R3 first step down after TOP", int'(count), 254);
    wr(1'b1, 20);
    run(253);
    chk("R6 mode1 old value on down slope", w_first_mb, 99);
    run(300);
    chk("R6 mode1 old value kept through BOTTOM", w_first_mb, 101);
    run(300);
    chk("R6 mode1 new value after TOP", w_first_mb, 19);

    // R12: reserved modes behave like mode 0
    for (int m = 4; m <= 6; m += 2) begin
      do_reset();
      mode = 3'(m); cmode_b = 2'b11; cmode_a = 2'b01;
      wr(1'b1, 5);
      run(255);
      chk("R12 reserved reaches 255", int'(count), 255);
      chk("R12 reserved match", w_mb, 1);
      chk("R12 reserved set on match", int'(wave_b), 1);
      chk("R12 reserved no early overflow", w_ovf, 0);
      chk("R11 oe on for 01 outside PWM", int'(oe_a), 1);
      run(1);
      chk("R12 reserved wrap", int'(count), 0);
      chk("R12 reserved overflow at MAX", w_ovf, 1);
    end

    summary();
    $finish;
  end

endmodule